// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds instructions bound for one functional pipe between dispatch and execution. Each instruction arrives with two source operands. An operand that is already known comes with its value. An operand that is still being computed comes with the reorder-buffer tag of its producer. Dispatch never waits for missing data. The instruction takes a free station and listens to the common result bus. When the broadcast tag matches a missing operand, the station takes the value.

A station whose operands are all present may be sent into the pipe. The pool sends at most one instruction per cycle, and it picks the oldest by reorder-buffer tag age. Memory ordering is handled in the pool. A load waits while an older store to the same address is held in the pool. A store keeps its station after it issues and releases it only when the store-commit port names its tag. Flushes come in two forms. An exception flush clears every station. A mispredict flush removes only the stations that are younger than the branch.

Top module: `rs_pool`

## Requirements
- R1: After reset no station is occupied, `iss_valid` is low and `disp_full` is low.
- R2: A dispatched instruction whose two operands are both marked ready is offered on the issue port in the cycle after dispatch. It carries its own tag, kind and the dispatched operand values.
- R3: A missing operand is filled only by a result-bus broadcast whose tag equals the operand's producer tag. A broadcast with any other tag leaves the station waiting. A station is never issued before both operands are present, and it is issued in the cycle after the last operand is captured.
- R4: If a dispatched operand's producer tag is on the result bus in the dispatch cycle, the station stores that value at once and can issue in the next cycle.
- R5: An operand that was ready at dispatch is never overwritten by a later broadcast, even when the broadcast tag equals the tag field dispatched with that operand.
- R6: When several stations are eligible, the oldest by tag is issued first, and only one is issued per cycle. Tag a is older than tag b when (b - a) mod 2^TAG_W lies between 1 and 2^(TAG_W-1) - 1. A non-store station is freed once it issues.
- R7: `disp_full` is high exactly when all NUM_RS stations are occupied. A dispatch presented while it is high is dropped.
- R8: Kind codes are 0 for arithmetic, 1 for load and 2 for store. A load is not issued while a store with an older tag and an equal address occupies a station. A store keeps its station after issue until `st_commit_valid` arrives with its tag. A younger store, or an older store to a different address, does not hold a load back.
- R9: `flush_all` empties every station. In any cycle in which `flush_all` or `flush_br_valid` is high, `iss_valid` is low and a dispatch is dropped.
- R10: `flush_br_valid` removes only the stations whose tag is younger than `flush_br_tag`. The branch's own station and older stations stay in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Instruction kind: 0 arithmetic, 1 load, 2 store |
| disp_tag | input | TAG_W | Reorder-buffer tag of the instruction |
| disp_addr | input | ADDR_W | Effective address (loads and stores) |
| disp_s0_rdy | input | 1 | Operand 0 value already known |
| disp_s0_tag | input | TAG_W | Producer tag of operand 0 |
| disp_s0_val | input | DATA_W | Value of operand 0 |
| disp_s1_rdy | input | 1 | Operand 1 value already known |
| disp_s1_tag | input | TAG_W | Producer tag of operand 1 |
| disp_s1_val | input | DATA_W | Value of operand 1 |
| disp_full | output | 1 | No free station |
| res_valid | input | 1 | Result-bus broadcast valid |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_data | input | DATA_W | Broadcast result value |
| st_commit_valid | input | 1 | A store has committed |
| st_commit_tag | input | TAG_W | Tag of the committed store |
| flush_all | input | 1 | Exception flush of all stations |
| flush_br_valid | input | 1 | Mispredict flush |
| flush_br_tag | input | TAG_W | Tag of the mispredicted branch |
| iss_valid | output | 1 | Instruction sent to the pipe this cycle |
| iss_kind | output | 2 | Kind of the issued instruction |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| iss_addr | output | ADDR_W | Address of the issued instruction |
| iss_op0 | output | DATA_W | Operand 0 value |
| iss_op1 | output | DATA_W | Operand 1 value |

## Verification
Several properties are checked on every cycle. The issue port stays quiet during any flush. An exception flush leaves the pool empty. No new station is taken during a mispredict flush or while the pool is full. The same tag never issues in two consecutive cycles. An issued load never has an older matching store still in the pool. The bench scenarios cover what needs a planned sequence of events: which operand value reaches the pipe after a tag match or a same-cycle bypass, the oldest-first order across tag wrap-around, and which stations survive a mispredict flush.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2
    } kind_e;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic              valid;
        logic              issued;
        kind_e             kind;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        opnd_t             s0;
        opnd_t             s1;
    } slot_t;

    // a is older than b in a wrapping tag space
    function automatic logic is_older(input logic [TAG_W-1:0] a,
                                      input logic [TAG_W-1:0] b);
        logic [TAG_W-1:0] d;
        d = b - a;
        return (d != '0) && !d[TAG_W-1];
    endfunction

    // fill a waiting operand from the result bus on a tag match
    function automatic opnd_t snoop(input opnd_t o,
                                    input logic bus_v,
                                    input logic [TAG_W-1:0] bus_tag,
                                    input logic [DATA_W-1:0] bus_data);
        opnd_t r;
        r = o;
        if (!o.rdy && bus_v && (o.tag == bus_tag)) begin
            r.rdy = 1'b1;
            r.val = bus_data;
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pool_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_alloc,
    input  slot_t             i_new,
    input  logic              i_res_valid,
    input  logic [TAG_W-1:0]  i_res_tag,
    input  logic [DATA_W-1:0] i_res_data,
    input  logic              i_grant,
    input  logic              i_commit_valid,
    input  logic [TAG_W-1:0]  i_commit_tag,
    input  logic              i_flush_all,
    input  logic              i_flush_br,
    input  logic [TAG_W-1:0]  i_br_tag,
    output slot_t             o_slot
);

    slot_t q;
    logic  kill_br;
    logic  commit_hit;

    assign kill_br    = i_flush_br && q.valid && is_older(i_br_tag, q.tag);
    assign commit_hit = i_commit_valid && q.issued && (q.tag == i_commit_tag);

    always_ff @(posedge clk) begin
        if (rst || i_flush_all) begin
            q <= '0;
        end else if (kill_br) begin
            q.valid  <= 1'b0;
            q.issued <= 1'b0;
        end else if (i_alloc) begin
            q <= i_new;
        end else if (q.valid) begin
            if (i_grant) begin
                if (q.kind == K_STORE) begin
                    q.issued <= 1'b1;
                end else begin
                    q.valid <= 1'b0;
                end
            end else if (commit_hit) begin
                q.valid  <= 1'b0;
                q.issued <= 1'b0;
            end else begin
                q.s0 <= snoop(q.s0, i_res_valid, i_res_tag, i_res_data);
                q.s1 <= snoop(q.s1, i_res_valid, i_res_tag, i_res_data);
            end
        end
    end

    assign o_slot = q;

endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int NUM_RS = 4
) (
    input  logic [NUM_RS-1:0] i_occ,
    output logic              o_any_free,
    output logic [NUM_RS-1:0] o_hot
);

    always_comb begin
        o_any_free = 1'b0;
        o_hot      = '0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (!i_occ[i]) begin
                o_any_free = 1'b1;
                o_hot      = '0;
                o_hot[i]   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_pick.sv
module rs_pick
    import rs_pool_pkg::*;
#(
    parameter int NUM_RS = 4,
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
    input  slot_t             i_slots [NUM_RS],
    output logic              o_found,
    output logic [IDX_W-1:0]  o_idx,
    output logic [NUM_RS-1:0] o_hot
);

    logic [NUM_RS-1:0] elig;

    // eligibility: operands present, not yet sent, loads not held by stores
    always_comb begin
        for (int i = 0; i < NUM_RS; i++) begin
            logic held;
            held = 1'b0;
            for (int j = 0; j < NUM_RS; j++) begin
                if (i_slots[j].valid && (i_slots[j].kind == K_STORE) &&
                    (i_slots[j].addr == i_slots[i].addr) &&
                    is_older(i_slots[j].tag, i_slots[i].tag)) begin
                    held = 1'b1;
                end
            end
            elig[i] = i_slots[i].valid && !i_slots[i].issued &&
                      i_slots[i].s0.rdy && i_slots[i].s1.rdy &&
                      !((i_slots[i].kind == K_LOAD) && held);
        end
    end

    // oldest eligible station wins
    always_comb begin
        o_found = 1'b0;
        o_idx   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (elig[i] && (!o_found || is_older(i_slots[i].tag, i_slots[o_idx].tag))) begin
                o_found = 1'b1;
                o_idx   = IDX_W'(i);
            end
        end
        for (int i = 0; i < NUM_RS; i++) begin
            o_hot[i] = o_found && (o_idx == IDX_W'(i));
        end
    end

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int NUM_RS = 4,
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [1:0]        disp_kind,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic [ADDR_W-1:0] disp_addr,
    input  logic              disp_s0_rdy,
    input  logic [TAG_W-1:0]  disp_s0_tag,
    input  logic [DATA_W-1:0] disp_s0_val,
    input  logic              disp_s1_rdy,
    input  logic [TAG_W-1:0]  disp_s1_tag,
    input  logic [DATA_W-1:0] disp_s1_val,
    output logic              disp_full,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              st_commit_valid,
    input  logic [TAG_W-1:0]  st_commit_tag,
    input  logic              flush_all,
    input  logic              flush_br_valid,
    input  logic [TAG_W-1:0]  flush_br_tag,
    output logic              iss_valid,
    output logic [1:0]        iss_kind,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [DATA_W-1:0] iss_op0,
    output logic [DATA_W-1:0] iss_op1
);

    slot_t             slots [NUM_RS];
    slot_t             new_slot;
    logic [NUM_RS-1:0] occ_vec;
    logic [NUM_RS-1:0] alloc_hot;
    logic [NUM_RS-1:0] pick_hot;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_found;
    logic              any_free;
    logic              any_flush;
    logic              accept;

    assign any_flush = flush_all || flush_br_valid;
    assign accept    = disp_valid && any_free && !any_flush;
    assign disp_full = !any_free;
    assign iss_valid = pick_found && !any_flush;

    // dispatch payload, with same-cycle result bypass
    always_comb begin
        new_slot        = '0;
        new_slot.valid  = 1'b1;
        new_slot.issued = 1'b0;
        new_slot.kind   = kind_e'(disp_kind);
        new_slot.tag    = disp_tag;
        new_slot.addr   = disp_addr;
        new_slot.s0     = snoop(opnd_t'{disp_s0_rdy, disp_s0_tag, disp_s0_val},
                                res_valid, res_tag, res_data);
        new_slot.s1     = snoop(opnd_t'{disp_s1_rdy, disp_s1_tag, disp_s1_val},
                                res_valid, res_tag, res_data);
    end

    rs_alloc #(.NUM_RS(NUM_RS)) u_alloc (
        .i_occ      (occ_vec),
        .o_any_free (any_free),
        .o_hot      (alloc_hot)
    );

    rs_pick #(.NUM_RS(NUM_RS)) u_pick (
        .i_slots (slots),
        .o_found (pick_found),
        .o_idx   (pick_idx),
        .o_hot   (pick_hot)
    );

    for (genvar g = 0; g < NUM_RS; g++) begin : g_slot
        rs_slot u_slot (
            .clk            (clk),
            .rst            (rst),
            .i_alloc        (accept && alloc_hot[g]),
            .i_new          (new_slot),
            .i_res_valid    (res_valid),
            .i_res_tag      (res_tag),
            .i_res_data     (res_data),
            .i_grant        (iss_valid && pick_hot[g]),
            .i_commit_valid (st_commit_valid),
            .i_commit_tag   (st_commit_tag),
            .i_flush_all    (flush_all),
            .i_flush_br     (flush_br_valid),
            .i_br_tag       (flush_br_tag),
            .o_slot         (slots[g])
        );
        assign occ_vec[g] = slots[g].valid;
    end

    assign iss_kind = slots[pick_idx].kind;
    assign iss_tag  = slots[pick_idx].tag;
    assign iss_addr = slots[pick_idx].addr;
    assign iss_op0  = slots[pick_idx].s0.val;
    assign iss_op1  = slots[pick_idx].s1.val;

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk
    import rs_pool_pkg::*;
#(
    parameter int NUM_RS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              disp_valid,
    input logic              disp_full,
    input logic              flush_all,
    input logic              flush_br_valid,
    input logic              iss_valid,
    input logic [1:0]        iss_kind,
    input logic [TAG_W-1:0]  iss_tag,
    input logic [ADDR_W-1:0] iss_addr,
    input slot_t             slots [NUM_RS],
    input logic [NUM_RS-1:0] occ
);

    function automatic logic older_store_same_addr(input logic [TAG_W-1:0] t,
                                                   input logic [ADDR_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int j = 0; j < NUM_RS; j++) begin
            if (slots[j].valid && (slots[j].kind == K_STORE) &&
                (slots[j].addr == a) && is_older(slots[j].tag, t)) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ == '0) && !iss_valid && !disp_full);

    a_r9_quiet_on_flush: assert property (@(posedge clk) disable iff (rst)
        (flush_all || flush_br_valid) |-> !iss_valid);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (occ == '0));

    a_r9_no_alloc_on_branch_flush: assert property (@(posedge clk) disable iff (rst)
        flush_br_valid |=> ((occ & ~$past(occ)) == '0));

    a_r7_no_alloc_when_full: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_full) |=> ($countones(occ) <= $past($countones(occ))));

    a_r6_no_double_issue: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !(iss_valid && (iss_tag == $past(iss_tag))));

    a_r8_load_order: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && (iss_kind == 2'd1)) |-> !older_store_same_addr(iss_tag, iss_addr));

endmodule

bind rs_pool rs_pool_chk #(.NUM_RS(NUM_RS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .disp_valid     (disp_valid),
    .disp_full      (disp_full),
    .flush_all      (flush_all),
    .flush_br_valid (flush_br_valid),
    .iss_valid      (iss_valid),
    .iss_kind       (iss_kind),
    .iss_tag        (iss_tag),
    .iss_addr       (iss_addr),
    .slots          (slots),
    .occ            (occ_vec)
);

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
    import rs_pool_pkg::*;

    localparam int KA = 0;
    localparam int KL = 1;
    localparam int KS = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              disp_valid = 1'b0;
    logic [1:0]        disp_kind = '0;
    logic [TAG_W-1:0]  disp_tag = '0;
    logic [ADDR_W-1:0] disp_addr = '0;
    logic              disp_s0_rdy = 1'b0;
    logic [TAG_W-1:0]  disp_s0_tag = '0;
    logic [DATA_W-1:0] disp_s0_val = '0;
    logic              disp_s1_rdy = 1'b0;
    logic [TAG_W-1:0]  disp_s1_tag = '0;
    logic [DATA_W-1:0] disp_s1_val = '0;
    logic              disp_full;
    logic              res_valid = 1'b0;
    logic [TAG_W-1:0]  res_tag = '0;
    logic [DATA_W-1:0] res_data = '0;
    logic              st_commit_valid = 1'b0;
    logic [TAG_W-1:0]  st_commit_tag = '0;
    logic              flush_all = 1'b0;
    logic              flush_br_valid = 1'b0;
    logic [TAG_W-1:0]  flush_br_tag = '0;
    logic              iss_valid;
    logic [1:0]        iss_kind;
    logic [TAG_W-1:0]  iss_tag;
    logic [ADDR_W-1:0] iss_addr;
    logic [DATA_W-1:0] iss_op0;
    logic [DATA_W-1:0] iss_op1;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rs_pool u_dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic ok,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic dispatch(input int kind, input int tag, input int addr,
                            input bit r0, input int t0, input int v0,
                            input bit r1, input int t1, input int v1);
        disp_valid  = 1'b1;
        disp_kind   = 2'(kind);
        disp_tag    = TAG_W'(tag);
        disp_addr   = ADDR_W'(addr);
        disp_s0_rdy = r0;
        disp_s0_tag = TAG_W'(t0);
        disp_s0_val = DATA_W'(v0);
        disp_s1_rdy = r1;
        disp_s1_tag = TAG_W'(t1);
        disp_s1_val = DATA_W'(v1);
        tick();
        disp_valid  = 1'b0;
    endtask

    task automatic bcast(input int tag, input int data);
        res_valid = 1'b1;
        res_tag   = TAG_W'(tag);
        res_data  = DATA_W'(data);
        tick();
        res_valid = 1'b0;
    endtask

    task automatic expect_issue(input string req, input int kind, input int tag,
                                input int op0, input int op1);
        check(req, iss_valid === 1'b1, longint'(iss_valid), 1);
        check(req, iss_tag === TAG_W'(tag), longint'(iss_tag), longint'(tag));
        check(req, iss_kind === 2'(kind), longint'(iss_kind), longint'(kind));
        check(req, iss_op0 === DATA_W'(op0) && iss_op1 === DATA_W'(op1),
              {32'(iss_op0), 32'(iss_op1)}, {32'(op0), 32'(op1)});
        tick();
    endtask

    task automatic expect_none(input string req);
        check(req, iss_valid === 1'b0, longint'(iss_valid), 0);
    endtask

    task automatic clear_all();
        flush_all = 1'b1;
        tick();
        flush_all = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 no issue after reset", iss_valid === 1'b0, longint'(iss_valid), 0);
        check("R1 not full after reset", disp_full === 1'b0, longint'(disp_full), 0);
    endtask

    task automatic t_ready_dispatch();
        dispatch(KA, 1, 0, 1, 0, 16'h1234, 1, 0, 16'h5678);
        expect_issue("R2 ready at dispatch", KA, 1, 16'h1234, 16'h5678);
        expect_none("R6 freed after issue");
        clear_all();
    endtask

    task automatic t_tag_wakeup();
        dispatch(KA, 2, 0, 1, 0, 16'h1111, 0, 9, 0);
        expect_none("R3 waits for operand");
        bcast(8, 16'hDEAD);
        expect_none("R3 mismatched tag ignored");
        bcast(9, 16'h2222);
        expect_issue("R3 captured on match", KA, 2, 16'h1111, 16'h2222);
        clear_all();
    endtask

    task automatic t_bypass();
        res_valid = 1'b1;
        res_tag   = 4'd7;
        res_data  = 16'h7777;
        dispatch(KA, 3, 0, 0, 7, 0, 1, 0, 16'h0003);
        res_valid = 1'b0;
        expect_issue("R4 same-cycle bypass", KA, 3, 16'h7777, 16'h0003);
        clear_all();
    endtask

    task automatic t_war();
        dispatch(KA, 3, 0, 1, 6, 16'hAAAA, 0, 6, 0);
        bcast(6, 16'hBBBB);
        expect_issue("R5 captured operand kept", KA, 3, 16'hAAAA, 16'hBBBB);
        clear_all();
    endtask

    task automatic t_oldest();
        dispatch(KA, 4, 0, 0, 1, 0, 1, 0, 4);
        dispatch(KA, 2, 0, 0, 1, 0, 1, 0, 2);
        dispatch(KA, 3, 0, 0, 1, 0, 1, 0, 3);
        bcast(1, 16'h0101);
        expect_issue("R6 oldest first", KA, 2, 16'h0101, 2);
        expect_issue("R6 second oldest", KA, 3, 16'h0101, 3);
        expect_issue("R6 youngest last", KA, 4, 16'h0101, 4);
        expect_none("R6 drained");
        dispatch(KA, 0, 0, 0, 1, 0, 1, 0, 16'h0010);
        dispatch(KA, 15, 0, 0, 1, 0, 1, 0, 16'h0015);
        bcast(1, 16'h0202);
        expect_issue("R6 wrap older", KA, 15, 16'h0202, 16'h0015);
        expect_issue("R6 wrap younger", KA, 0, 16'h0202, 16'h0010);
        clear_all();
    endtask

    task automatic t_full();
        for (int i = 1; i <= 4; i++) dispatch(KA, i, 0, 0, 9, 0, 1, 0, i);
        check("R7 full when all occupied", disp_full === 1'b1, longint'(disp_full), 1);
        dispatch(KA, 5, 0, 1, 0, 16'h5555, 1, 0, 16'h5555);
        expect_none("R7 dispatch while full dropped");
        check("R7 still full", disp_full === 1'b1, longint'(disp_full), 1);
        bcast(9, 16'h0909);
        for (int i = 1; i <= 4; i++) expect_issue("R7 original entries", KA, i, 16'h0909, i);
        expect_none("R7 dropped entry never issues");
        check("R7 free after drain", disp_full === 1'b0, longint'(disp_full), 0);
        clear_all();
    endtask

    task automatic t_mem_order();
        dispatch(KS, 2, 8'h40, 1, 0, 16'h00A0, 1, 0, 16'h00D0);
        expect_issue("R8 store issues", KS, 2, 16'h00A0, 16'h00D0);
        dispatch(KL, 3, 8'h40, 1, 0, 16'h0003, 1, 0, 0);
        expect_none("R8 load held by older store");
        dispatch(KL, 4, 8'h41, 1, 0, 16'h0004, 1, 0, 0);
        expect_issue("R8 other address not held", KL, 4, 16'h0004, 0);
        expect_none("R8 load still held");
        st_commit_valid = 1'b1;
        st_commit_tag   = 4'd2;
        tick();
        st_commit_valid = 1'b0;
        expect_issue("R8 load released by commit", KL, 3, 16'h0003, 0);
        dispatch(KS, 7, 8'h50, 1, 0, 16'h0007, 1, 0, 16'h0070);
        expect_issue("R8 second store issues", KS, 7, 16'h0007, 16'h0070);
        dispatch(KL, 6, 8'h50, 1, 0, 16'h0006, 1, 0, 0);
        expect_issue("R8 younger store not blocking", KL, 6, 16'h0006, 0);
        clear_all();
    endtask

    task automatic t_flush_all();
        dispatch(KA, 10, 0, 0, 1, 0, 1, 0, 10);
        dispatch(KA, 11, 0, 0, 1, 0, 1, 0, 11);
        dispatch(KA, 12, 0, 1, 0, 16'h0C0C, 1, 0, 12);
        flush_all  = 1'b1;
        disp_valid = 1'b1;
        disp_kind  = 2'd0;
        disp_tag   = 4'd13;
        disp_s0_rdy = 1'b1;
        disp_s1_rdy = 1'b1;
        #1;
        expect_none("R9 no issue during flush");
        tick();
        flush_all  = 1'b0;
        disp_valid = 1'b0;
        check("R9 empty after flush", disp_full === 1'b0, longint'(disp_full), 0);
        expect_none("R9 flushed ready entry gone");
        bcast(1, 16'h0111);
        expect_none("R9 flushed waiters gone");
        tick();
        expect_none("R9 dispatch in flush dropped");
    endtask

    task automatic t_flush_branch();
        dispatch(KA, 3, 0, 1, 0, 3, 0, 1, 0);
        dispatch(KA, 5, 0, 1, 0, 5, 0, 1, 0);
        dispatch(KA, 8, 0, 1, 0, 8, 0, 1, 0);
        flush_br_valid = 1'b1;
        flush_br_tag   = 4'd5;
        tick();
        flush_br_valid = 1'b0;
        bcast(1, 16'h0E0E);
        expect_issue("R10 older survives", KA, 3, 3, 16'h0E0E);
        expect_issue("R10 branch survives", KA, 5, 5, 16'h0E0E);
        expect_none("R10 younger removed");
        clear_all();
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        tick();
        t_reset();
        t_ready_dispatch();
        t_tag_wakeup();
        t_bypass();
        t_war();
        t_oldest();
        t_full();
        t_mem_order();
        t_flush_all();
        t_flush_branch();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule